// File: doc/BRIEF.md
# Receive Descriptor Ring Sequencer

This block moves a serial channel's received bytes into memory buffers that software describes in a table of receive descriptors. It holds the table base address and a pointer to the current descriptor. From each ready descriptor it fetches the buffer address, and then it writes each incoming byte to the next location of that buffer through a simple memory port. A down-counter bounds every buffer at the maximum receive length. That length is taken from its input only when a new descriptor is loaded.

A buffer closes in one of three cases: the counter runs out, an error arrives, or an end-of-frame arrives. On closing, the block writes the byte count and an updated status back into the descriptor. It then moves to the next descriptor, or returns to the table base when the closed descriptor carries the wrap flag. If a descriptor is not marked empty, the block waits at that descriptor, polls it, and raises a busy indication.

Each descriptor is 8 bytes, stored little-endian. The status halfword is at offset 0, the length halfword at offset 2, and the 32-bit buffer address at offset 4. The status bits are: bit 15 empty, bit 13 wrap, bit 11 end-of-frame, bit 1 error.

Top module: `rx_bd_seq`

## Requirements
- R1: After reset `cur_bd_o` equals the base reset value. A base write made while no buffer is open also reloads the pointer with the new base.
- R2: After closing a descriptor whose status bit 13 (wrap) is set, the pointer returns to the table base. Otherwise it advances by 8.
- R3: The low three bits of a written base are dropped. `base_misalign_o` is 1 exactly when the last base write had any of them set.
- R4: With no event pending, a buffer closes after exactly the maximum length of bytes. The close writes that count into the length halfword (offset 2) and rewrites the status with bit 15 cleared and bits 11 and 1 unchanged.
- R5: The maximum length is sampled when the buffer address is loaded. A change while a buffer is open takes effect at the next descriptor.
- R6: `rx_eof_i` closes the open buffer early and sets status bit 11. `rx_err_i` closes it early and sets status bit 1, and it takes priority over `rx_eof_i`. In both cases the length written is the number of bytes stored.
- R7: `mrblr_bad_o` is 1 when the maximum length is zero, or when it is odd while `wide_char_i` is 1.
- R8: A pointer write is taken only while `rx_en_i` is 0 or no buffer is open. A pointer write while a buffer is open is ignored.
- R9: Bytes go to consecutive addresses starting at the buffer address read from descriptor offset 4.
- R10: When the current descriptor's status bit 15 is clear, `busy_o` is 1 and `rx_ready_o` is 0, and no data is written. Work resumes once software sets the bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_en_i | input | 1 | Receiver enable |
| base_we_i | input | 1 | Table base write strobe |
| base_i | input | AW | Table base write value |
| ptr_we_i | input | 1 | Descriptor pointer write strobe |
| ptr_i | input | AW | Descriptor pointer write value |
| mrblr_i | input | LW | Maximum receive buffer length |
| wide_char_i | input | 1 | Characters wider than 8 bits |
| rx_valid_i | input | 1 | Received byte valid |
| rx_data_i | input | 8 | Received byte |
| rx_eof_i | input | 1 | End of frame event |
| rx_err_i | input | 1 | Receive error event |
| rx_ready_o | output | 1 | Byte or event accepted this cycle |
| busy_o | output | 1 | Current descriptor not empty, stalled |
| base_misalign_o | output | 1 | Last base write was misaligned |
| mrblr_bad_o | output | 1 | Maximum length illegal for mode |
| cur_bd_o | output | AW | Current descriptor address |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Memory write |
| mem_size_o | output | 2 | 0 byte, 1 halfword, 2 word |
| mem_addr_o | output | AW | Memory byte address |
| mem_wdata_o | output | 32 | Write data, right-aligned |
| mem_gnt_i | input | 1 | Access completes this cycle |
| mem_rdata_i | input | 32 | Read data, valid with grant |

## Verification
The bench builds the block with a 16-bit address, a 16-bit length and a base reset value of 0x0040. The memory model is 256 bytes. A three-descriptor ring with the wrap flag on its last entry fits in that memory. Maximum lengths of 4 and 2 make full-buffer closes, the wrap back to the base and a mid-buffer length change reachable in a few dozen cycles. Re-using descriptors that have already been closed drives the block into its busy stall without any extra setup.

// File: rtl/rx_bd_pkg.sv
package rx_bd_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_FETCH_ST, S_FETCH_BA, S_OPEN, S_WB_LEN, S_WB_ST
  } seq_state_e;

  localparam int unsigned EMPTY_BIT = 15;
  localparam int unsigned WRAP_BIT  = 13;
  localparam int unsigned LAST_BIT  = 11;
  localparam int unsigned ERR_BIT   = 1;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
  localparam logic [1:0] SZ_WORD = 2'd2;

  localparam int unsigned BD_BYTES = 8;
  localparam int unsigned OFS_LEN  = 2;
  localparam int unsigned OFS_BUF  = 4;
endpackage

// File: rtl/rx_bd_cfg.sv
module rx_bd_cfg #(
  parameter int unsigned AW = 32,
  parameter int unsigned LW = 16,
  parameter logic [AW-1:0] BASE_RST = '0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          base_we_i,
  input  logic [AW-1:0] base_i,
  input  logic          wide_char_i,
  input  logic [LW-1:0] mrblr_i,
  output logic [AW-1:0] base_o,
  output logic          misalign_o,
  output logic          mrblr_bad_o
);
  localparam logic [AW-1:0] ALIGN_MASK = ~AW'(7);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_o     <= BASE_RST & ALIGN_MASK;
      misalign_o <= 1'b0;
    end else if (base_we_i) begin
      base_o     <= base_i & ALIGN_MASK;
      misalign_o <= |base_i[2:0];
    end
  end

  assign mrblr_bad_o = (mrblr_i == '0) | (wide_char_i & mrblr_i[0]);
endmodule

// File: rtl/rx_bd_buf.sv
module rx_bd_buf #(
  parameter int unsigned AW = 32,
  parameter int unsigned LW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] addr_i,
  input  logic [LW-1:0] mrblr_i,
  input  logic          step_i,
  output logic [AW-1:0] ptr_o,
  output logic [LW-1:0] len_o,
  output logic [LW-1:0] max_o,
  output logic          last_o
);
  logic [LW-1:0] cnt_q;
  logic [LW-1:0] eff_max;

  // zero length is flagged elsewhere; treat it as one byte
  assign eff_max = (mrblr_i == '0) ? LW'(1) : mrblr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_o <= '0;
      cnt_q <= '0;
      max_o <= '0;
    end else if (load_i) begin
      ptr_o <= addr_i;
      cnt_q <= eff_max;
      max_o <= eff_max;
    end else if (step_i) begin
      ptr_o <= ptr_o + AW'(1);
      cnt_q <= cnt_q - LW'(1);
    end
  end

  assign len_o  = max_o - cnt_q;
  assign last_o = (cnt_q == LW'(1));
endmodule

// File: rtl/rx_bd_seq.sv
module rx_bd_seq
  import rx_bd_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned LW = 16,
  parameter logic [AW-1:0] BASE_RST = '0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rx_en_i,
  input  logic          base_we_i,
  input  logic [AW-1:0] base_i,
  input  logic          ptr_we_i,
  input  logic [AW-1:0] ptr_i,
  input  logic [LW-1:0] mrblr_i,
  input  logic          wide_char_i,
  input  logic          rx_valid_i,
  input  logic [7:0]    rx_data_i,
  input  logic          rx_eof_i,
  input  logic          rx_err_i,
  output logic          rx_ready_o,
  output logic          busy_o,
  output logic          base_misalign_o,
  output logic          mrblr_bad_o,
  output logic [AW-1:0] cur_bd_o,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [1:0]    mem_size_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [31:0]   mem_wdata_o,
  input  logic          mem_gnt_i,
  input  logic [31:0]   mem_rdata_i
);
  localparam logic [AW-1:0] ALIGN_MASK = ~AW'(7);

  seq_state_e    state_q;
  logic [AW-1:0] base_w;
  logic [AW-1:0] buf_ptr;
  logic [LW-1:0] buf_len;
  logic [LW-1:0] mrblr_q;
  logic          buf_last;
  logic [15:0]   st_q;
  logic          fl_eof_q, fl_err_q;
  logic          ptr_ok, ptr_acc, base_acc;
  logic          byte_acc, buf_load;
  logic [15:0]   st_out;

  rx_bd_cfg #(.AW(AW), .LW(LW), .BASE_RST(BASE_RST)) u_cfg (
    .clk_i, .rst_ni, .base_we_i, .base_i, .wide_char_i, .mrblr_i,
    .base_o(base_w), .misalign_o(base_misalign_o), .mrblr_bad_o
  );

  rx_bd_buf #(.AW(AW), .LW(LW)) u_buf (
    .clk_i, .rst_ni,
    .load_i(buf_load), .addr_i(mem_rdata_i[AW-1:0]), .mrblr_i,
    .step_i(byte_acc),
    .ptr_o(buf_ptr), .len_o(buf_len), .max_o(mrblr_q), .last_o(buf_last)
  );

  assign ptr_ok   = !rx_en_i || state_q == S_IDLE || state_q == S_FETCH_ST;
  assign ptr_acc  = ptr_ok && ptr_we_i;
  assign base_acc = ptr_ok && base_we_i && !ptr_we_i;

  assign rx_ready_o = (state_q == S_OPEN) && mem_gnt_i;
  assign byte_acc   = rx_ready_o && rx_valid_i && !rx_err_i && !rx_eof_i;
  assign buf_load   = (state_q == S_FETCH_BA) && mem_gnt_i;

  always_comb begin
    st_out = st_q;
    st_out[EMPTY_BIT] = 1'b0;
    st_out[LAST_BIT]  = st_q[LAST_BIT] | fl_eof_q;
    st_out[ERR_BIT]   = st_q[ERR_BIT] | fl_err_q;
  end

  always_comb begin
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_size_o  = SZ_HALF;
    mem_addr_o  = cur_bd_o;
    mem_wdata_o = '0;
    unique case (state_q)
      S_FETCH_ST: mem_req_o = 1'b1;
      S_FETCH_BA: begin
        mem_req_o  = 1'b1;
        mem_size_o = SZ_WORD;
        mem_addr_o = cur_bd_o + AW'(OFS_BUF);
      end
      S_OPEN: begin
        mem_req_o   = rx_valid_i && !rx_err_i && !rx_eof_i;
        mem_we_o    = 1'b1;
        mem_size_o  = SZ_BYTE;
        mem_addr_o  = buf_ptr;
        mem_wdata_o = {24'd0, rx_data_i};
      end
      S_WB_LEN: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = cur_bd_o + AW'(OFS_LEN);
        mem_wdata_o = 32'(buf_len);
      end
      S_WB_ST: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_wdata_o = {16'd0, st_out};
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= S_IDLE;
      cur_bd_o <= BASE_RST & ALIGN_MASK;
      st_q     <= '0;
      fl_eof_q <= 1'b0;
      fl_err_q <= 1'b0;
      busy_o   <= 1'b0;
    end else begin
      if (ptr_acc)       cur_bd_o <= ptr_i & ALIGN_MASK;
      else if (base_acc) cur_bd_o <= base_i & ALIGN_MASK;
      unique case (state_q)
        S_IDLE: begin
          busy_o <= 1'b0;
          if (rx_en_i) state_q <= S_FETCH_ST;
        end
        S_FETCH_ST: begin
          if (!rx_en_i) begin
            state_q <= S_IDLE;
            busy_o  <= 1'b0;
          end else if (!ptr_acc && !base_acc && mem_gnt_i) begin
            st_q   <= mem_rdata_i[15:0];
            busy_o <= !mem_rdata_i[EMPTY_BIT];
            if (mem_rdata_i[EMPTY_BIT]) state_q <= S_FETCH_BA;
          end
        end
        S_FETCH_BA: if (mem_gnt_i) state_q <= S_OPEN;
        S_OPEN: begin
          if (rx_err_i) begin
            fl_err_q <= 1'b1;
            state_q  <= S_WB_LEN;
          end else if (rx_eof_i) begin
            fl_eof_q <= 1'b1;
            state_q  <= S_WB_LEN;
          end else if (byte_acc && buf_last) begin
            state_q  <= S_WB_LEN;
          end
        end
        S_WB_LEN: if (mem_gnt_i) state_q <= S_WB_ST;
        S_WB_ST: if (mem_gnt_i) begin
          cur_bd_o <= st_q[WRAP_BIT] ? base_w : cur_bd_o + AW'(BD_BYTES);
          fl_eof_q <= 1'b0;
          fl_err_q <= 1'b0;
          state_q  <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rx_bd_seq_chk.sv
module rx_bd_seq_chk
  import rx_bd_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned LW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input seq_state_e    state_i,
  input logic [AW-1:0] cur_bd_i,
  input logic [AW-1:0] base_i,
  input logic [LW-1:0] mrblr_q_i,
  input logic [AW-1:0] buf_ptr_i,
  input logic          mem_req_i,
  input logic          mem_we_i,
  input logic [1:0]    mem_size_i,
  input logic [AW-1:0] mem_addr_i,
  input logic [31:0]   mem_wdata_i,
  input logic          mem_gnt_i,
  input logic          busy_i
);
  logic          byte_wr, st_wr;
  logic [LW-1:0] nb_q;

  assign byte_wr = mem_req_i && mem_we_i && mem_gnt_i && mem_size_i == SZ_BYTE;
  assign st_wr   = mem_req_i && mem_we_i && mem_gnt_i && state_i == S_WB_ST;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  nb_q <= '0;
    else if (state_i == S_FETCH_BA) nb_q <= '0;
    else if (byte_wr)             nb_q <= nb_q + LW'(1);
  end

  // R4
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_wr |-> nb_q < mrblr_q_i);

  // R3
  bd_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cur_bd_i[2:0] == 3'b000);

  // R5
  max_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == S_OPEN && $past(state_i == S_OPEN)) |-> $stable(mrblr_q_i));

  // R8
  ptr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_i == S_OPEN |=> $stable(cur_bd_i));

  // R9
  data_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_wr |=> buf_ptr_i == $past(mem_addr_i) + AW'(1));

  // R2
  wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_wr && mem_wdata_i[WRAP_BIT]) |=> cur_bd_i == $past(base_i));

  // R2
  advance_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_wr && !mem_wdata_i[WRAP_BIT]) |=> cur_bd_i == $past(cur_bd_i) + AW'(BD_BYTES));

  // R10
  stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> !byte_wr);
endmodule

bind rx_bd_seq rx_bd_seq_chk #(.AW(AW), .LW(LW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .state_i(state_q), .cur_bd_i(cur_bd_o),
  .base_i(base_w), .mrblr_q_i(mrblr_q), .buf_ptr_i(buf_ptr),
  .mem_req_i(mem_req_o), .mem_we_i(mem_we_o), .mem_size_i(mem_size_o),
  .mem_addr_i(mem_addr_o), .mem_wdata_i(mem_wdata_o), .mem_gnt_i(mem_gnt_i),
  .busy_i(busy_o)
);

// File: tb/rx_bd_seq_tb.sv
module rx_bd_seq_tb;
  localparam int unsigned AW = 16;
  localparam int unsigned LW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic          rx_en = 0, base_we = 0, ptr_we = 0, wide = 0;
  logic [AW-1:0] base_d = '0, ptr_d = '0;
  logic [LW-1:0] mrblr = 16'd4;
  logic          rx_valid = 0, rx_eof = 0, rx_err = 0;
  logic [7:0]    rx_data = '0;
  logic          rx_ready, busy, misalign, mrblr_bad;
  logic [AW-1:0] cur_bd;
  logic          mem_req, mem_we;
  logic [1:0]    mem_size;
  logic [AW-1:0] mem_addr;
  logic [31:0]   mem_wdata, mem_rdata;

  logic [7:0]  mem [256];
  logic        tb_we = 0;
  logic [7:0]  tb_a = '0;
  logic [15:0] tb_d = '0;
  logic [7:0]  ra;

  int n_chk = 0, n_bad = 0;

  rx_bd_seq #(.AW(AW), .LW(LW), .BASE_RST(16'h0040)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .rx_en_i(rx_en),
    .base_we_i(base_we), .base_i(base_d), .ptr_we_i(ptr_we), .ptr_i(ptr_d),
    .mrblr_i(mrblr), .wide_char_i(wide),
    .rx_valid_i(rx_valid), .rx_data_i(rx_data), .rx_eof_i(rx_eof), .rx_err_i(rx_err),
    .rx_ready_o(rx_ready), .busy_o(busy), .base_misalign_o(misalign),
    .mrblr_bad_o(mrblr_bad), .cur_bd_o(cur_bd),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_size_o(mem_size),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_gnt_i(1'b1),
    .mem_rdata_i(mem_rdata)
  );

  assign ra = mem_addr[7:0];
  assign mem_rdata = {mem[8'(ra + 8'd3)], mem[8'(ra + 8'd2)], mem[8'(ra + 8'd1)], mem[ra]};

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= 8'h00;
    end else begin
      if (mem_req && mem_we) begin
        mem[ra] <= mem_wdata[7:0];
        if (mem_size != 2'd0) mem[8'(ra + 8'd1)] <= mem_wdata[15:8];
      end
      if (tb_we) begin
        mem[tb_a] <= tb_d[7:0];
        mem[8'(tb_a + 8'd1)] <= tb_d[15:8];
      end
    end
  end

  function automatic logic [15:0] rd16(input logic [7:0] a);
    return {mem[8'(a + 8'd1)], mem[a]};
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic put16(input logic [7:0] a, input logic [15:0] v);
    @(negedge clk); tb_we = 1; tb_a = a; tb_d = v;
    @(negedge clk); tb_we = 0;
  endtask

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk);
    while (!rx_ready) @(negedge clk);
    rx_valid = 1; rx_data = b;
    @(negedge clk); rx_valid = 0;
  endtask

  task automatic send_evt(input bit err);
    @(negedge clk);
    while (!rx_ready) @(negedge clk);
    if (err) rx_err = 1; else rx_eof = 1;
    @(negedge clk); rx_err = 0; rx_eof = 0;
  endtask

  task automatic settle();
    repeat (12) @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1 reset pointer", cur_bd, 16'h0040);
    check("R10 reset busy", busy, 0);
    check("R10 reset ready", rx_ready, 0);
  endtask

  task automatic t_base();
    @(negedge clk); base_we = 1; base_d = 16'h0043;
    @(negedge clk); base_we = 0;
    check("R3 low bits dropped", cur_bd, 16'h0040);
    check("R3 misalign flag", misalign, 1);
    @(negedge clk); base_we = 1; base_d = 16'h0060;
    @(negedge clk); base_we = 0;
    check("R3 misalign cleared", misalign, 0);
    check("R1 base reload", cur_bd, 16'h0060);
  endtask

  task automatic t_mrblr_flag();
    @(negedge clk); mrblr = 16'd5; wide = 1; #1;
    check("R7 odd wide", mrblr_bad, 1);
    wide = 0; #1;
    check("R7 odd narrow", mrblr_bad, 0);
    mrblr = 16'd0; #1;
    check("R7 zero", mrblr_bad, 1);
    mrblr = 16'd4; #1;
    check("R7 legal", mrblr_bad, 0);
  endtask

  task automatic t_ring_setup();
    put16(8'h60, 16'h8000); put16(8'h64, 16'h0080); put16(8'h66, 16'h0000);
    put16(8'h68, 16'h8000); put16(8'h6C, 16'h0090); put16(8'h6E, 16'h0000);
    put16(8'h70, 16'hA000); put16(8'h74, 16'h00A0); put16(8'h76, 16'h0000);
  endtask

  task automatic t_full();
    @(negedge clk); rx_en = 1;
    for (int i = 0; i < 4; i++) send_byte(8'hA0 + 8'(i));
    settle();
    check("R4 full length", rd16(8'h62), 4);
    check("R4 full status", rd16(8'h60), 16'h0000);
    check("R9 byte 0", mem[8'h80], 8'hA0);
    check("R9 byte 3", mem[8'h83], 8'hA3);
    check("R2 advance", cur_bd, 16'h0068);
  endtask

  task automatic t_eof();
    send_byte(8'h51); send_byte(8'h52);
    send_evt(0);
    settle();
    check("R6 eof length", rd16(8'h6A), 2);
    check("R6 eof status", rd16(8'h68), 16'h0800);
    check("R9 eof data", mem[8'h91], 8'h52);
    check("R2 advance 2", cur_bd, 16'h0070);
  endtask

  task automatic t_mid_change();
    send_byte(8'h61);
    @(negedge clk); mrblr = 16'd2;
    send_byte(8'h62); send_byte(8'h63); send_byte(8'h64);
    settle();
    check("R5 old max kept", rd16(8'h72), 4);
    check("R2 wrap status", rd16(8'h70), 16'h2000);
    check("R2 wrap to base", cur_bd, 16'h0060);
  endtask

  task automatic t_busy();
    check("R10 busy raised", busy, 1);
    check("R10 ready held low", rx_ready, 0);
    check("R10 no data written", mem[8'h80], 8'hA0);
    put16(8'h60, 16'h8000);
    settle();
    check("R10 busy cleared", busy, 0);
    send_byte(8'h11); send_byte(8'h22);
    settle();
    check("R5 new max used", rd16(8'h62), 2);
    check("R9 reuse data", mem[8'h81], 8'h22);
  endtask

  task automatic t_err_ptr();
    put16(8'h68, 16'h8000);
    send_byte(8'h33);
    @(negedge clk); ptr_we = 1; ptr_d = 16'h0070;
    @(negedge clk); ptr_we = 0;
    check("R8 write ignored while open", cur_bd, 16'h0068);
    @(negedge clk); rx_err = 1; rx_eof = 1;
    @(negedge clk); rx_err = 0; rx_eof = 0;
    settle();
    check("R6 err length", rd16(8'h6A), 1);
    check("R6 err priority status", rd16(8'h68), 16'h0002);
    check("R2 after err", cur_bd, 16'h0070);
    @(negedge clk); rx_en = 0;
    @(negedge clk); ptr_we = 1; ptr_d = 16'h0065;
    @(negedge clk); ptr_we = 0;
    check("R8 write taken when disabled", cur_bd, 16'h0060);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_base();
    t_mrblr_flag();
    t_ring_setup();
    t_full();
    t_eof();
    t_mid_change();
    settle();
    t_busy();
    t_err_ptr();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule